// File: doc/BRIEF.md
# Four-Bit ALU Slice with Lookahead Outputs

This block is a purely combinational arithmetic logic slice for two 4-bit operands. A 3-bit function code chooses one of eight operations: addition, subtraction in either order, three bitwise logic operations, and two constant results (all zeros or all ones). There is no carry-out pin. Instead, the slice reports whether it generates a carry on its own and whether it passes an incoming carry straight through. Both signals are active low and are meant for an external carry lookahead unit that combines several slices into a wider word.

For subtraction the caller holds the carry input high, so a result such as A minus B is formed as A + ~B + 1. The arithmetic is self-dual. If every operand bit and the carry input are inverted, the result comes out inverted. The same slice therefore serves operands stored active low, with results in the same convention.

The function code is `sel`. `sel[0]` is the least significant select bit. The code values below are given as unsigned numbers.

Top module: `alu4_slice`

## Requirements
- R1: With `sel` = 0 (clear), `f` is 0 for every value of `a`, `b` and `cin`.
- R2: With `sel` = 7 (preset), `f` is all ones for every value of `a`, `b` and `cin`.
- R3: With `sel` = 3 (add), `f` equals (a + b + cin) mod 16.
- R4: With `sel` = 2 (A minus B), `f` equals (a + ~b + cin) mod 16. With `cin` = 1 this is a − b mod 16.
- R5: With `sel` = 1 (B minus A), `f` equals (b + ~a + cin) mod 16. With `cin` = 1 this is b − a mod 16.
- R6: Codes 4, 5 and 6 give the bitwise results a XOR b, a OR b and a AND b.
- R7: In the logic and constant codes (0, 4, 5, 6, 7), `cin` has no effect on `f`.
- R8: In the arithmetic codes (1, 2, 3), `g_n` is low exactly when the two operands as the mode uses them sum to more than 15, that is, when a carry leaves the slice even with `cin` = 0.
- R9: In the arithmetic codes, `p_n` is low exactly when every bit position has at least one operand bit set, so that an incoming carry would pass through the whole slice.
- R10: In the logic and constant codes, `g_n` and `p_n` are both held high: the slice neither generates nor propagates a carry.
- R11: In the arithmetic codes, inverting `a`, `b` and `cin` inverts `f`, so active-low operands give an active-low result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 4 | First operand |
| b | input | 4 | Second operand |
| sel | input | 3 | Function code; `sel[0]` is the least significant select bit |
| cin | input | 1 | Carry into the least significant bit, active high |
| f | output | 4 | Function result |
| g_n | output | 1 | Group carry generate, active low |
| p_n | output | 1 | Group carry propagate, active low |

## Verification
The bench sweeps all 4096 combinations of operands, function code and carry input, which covers every code exhaustively. Expected results come from an integer reference model. The sweep separates:
- the two subtraction orders from each other;
- a generated carry from a propagated one;
- a logic or constant result that leaks `cin` from one that ignores it.

A second pass repeats every arithmetic vector with `a`, `b` and `cin` all inverted and expects the inverted result. This checks the active-low operand convention separately from the ordinary sums.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

  typedef enum logic [2:0] {
    FN_ZERO  = 3'd0,
    FN_BSUBA = 3'd1,
    FN_ASUBB = 3'd2,
    FN_ADD   = 3'd3,
    FN_XOR   = 3'd4,
    FN_OR    = 3'd5,
    FN_AND   = 3'd6,
    FN_ONES  = 3'd7
  } fn_e;

  function automatic logic fn_is_arith(input fn_e fn);
    return (fn == FN_BSUBA) || (fn == FN_ASUBB) || (fn == FN_ADD);
  endfunction

  function automatic logic fn_invert_a(input fn_e fn);
    return fn == FN_BSUBA;
  endfunction

  function automatic logic fn_invert_b(input fn_e fn);
    return fn == FN_ASUBB;
  endfunction

endpackage

// File: rtl/alu4_opsel.sv
module alu4_opsel
  import alu4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  fn_e              fn,
  output logic [WIDTH-1:0] x,
  output logic [WIDTH-1:0] y,
  output logic             arith
);

  always_comb begin
    x     = fn_invert_a(fn) ? ~a : a;
    y     = fn_invert_b(fn) ? ~b : b;
    arith = fn_is_arith(fn);
  end

endmodule

// File: rtl/alu4_gp_cells.sv
module alu4_gp_cells #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] gen,
  output logic [WIDTH-1:0] prop,
  output logic [WIDTH-1:0] half
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign gen[i]  = x[i] & y[i];
    assign prop[i] = x[i] | y[i];
    assign half[i] = x[i] ^ y[i];
  end

endmodule

// File: rtl/alu4_lookahead.sv
module alu4_lookahead #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] gen,
  input  logic [WIDTH-1:0] prop,
  input  logic             cin,
  output logic [WIDTH-1:0] carry_in_bit,
  output logic             grp_gen,
  output logic             grp_prop
);

  logic [WIDTH:0] chain;

  assign chain[0] = cin;
  for (genvar i = 0; i < WIDTH; i++) begin : g_chain
    assign chain[i+1]      = gen[i] | (prop[i] & chain[i]);
    assign carry_in_bit[i] = chain[i];
  end

  // Sum-of-products group terms: bit k generates and every bit above it propagates.
  always_comb begin
    logic term;
    grp_gen  = 1'b0;
    grp_prop = 1'b1;
    for (int k = 0; k < WIDTH; k++) begin
      term = gen[k];
      for (int j = k + 1; j < WIDTH; j++) term = term & prop[j];
      grp_gen  = grp_gen | term;
      grp_prop = grp_prop & prop[k];
    end
  end

  // The rippled carry out of the top bit must match the lookahead form.
  always_comb begin
    AST_CHAIN_MATCHES_GROUP: assert (chain[WIDTH] == (grp_gen | (grp_prop & cin))) // R8
      else $error("ripple carry disagrees with group generate/propagate");
  end

endmodule

// File: rtl/alu4_result.sv
module alu4_result
  import alu4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  fn_e              fn,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] half,
  input  logic [WIDTH-1:0] carry_in_bit,
  output logic [WIDTH-1:0] f
);

  always_comb begin
    unique case (fn)
      FN_ZERO:                   f = '0;
      FN_ONES:                   f = '1;
      FN_XOR:                    f = a ^ b;
      FN_OR:                     f = a | b;
      FN_AND:                    f = a & b;
      FN_BSUBA, FN_ASUBB, FN_ADD: f = half ^ carry_in_bit;
      default:                   f = '0;
    endcase
  end

endmodule

// File: rtl/alu4_slice.sv
module alu4_slice
  import alu4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [2:0]       sel,
  input  logic             cin,
  output logic [WIDTH-1:0] f,
  output logic             g_n,
  output logic             p_n
);

  localparam logic [WIDTH:0] MOD_MASK = {1'b0, {WIDTH{1'b1}}};

  fn_e              fn;
  logic [WIDTH-1:0] opx, opy;
  logic             arith_mode;
  logic [WIDTH-1:0] bit_gen, bit_prop, bit_half, bit_carry;
  logic             grp_gen, grp_prop;

  assign fn = fn_e'(sel);

  alu4_opsel #(.WIDTH(WIDTH)) u_opsel (
    .a(a), .b(b), .fn(fn), .x(opx), .y(opy), .arith(arith_mode)
  );

  alu4_gp_cells #(.WIDTH(WIDTH)) u_cells (
    .x(opx), .y(opy), .gen(bit_gen), .prop(bit_prop), .half(bit_half)
  );

  alu4_lookahead #(.WIDTH(WIDTH)) u_la (
    .gen(bit_gen), .prop(bit_prop), .cin(cin),
    .carry_in_bit(bit_carry), .grp_gen(grp_gen), .grp_prop(grp_prop)
  );

  alu4_result #(.WIDTH(WIDTH)) u_res (
    .fn(fn), .a(a), .b(b), .half(bit_half), .carry_in_bit(bit_carry), .f(f)
  );

  // Outside arithmetic the slice reports "no generate, no propagate".
  assign g_n = arith_mode ? ~grp_gen  : 1'b1;
  assign p_n = arith_mode ? ~grp_prop : 1'b1;

  always_comb begin
    logic [WIDTH:0] wide_sum;
    wide_sum = ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}) & MOD_MASK;
    if (fn == FN_ZERO) begin
      AST_CLEAR_IS_ZERO: assert (f == '0) // R1
        else $error("clear code produced nonzero result");
    end
    if (fn == FN_ONES) begin
      AST_PRESET_IS_ONES: assert (f == '1) // R2
        else $error("preset code produced a zero bit");
    end
    if (fn == FN_ADD) begin
      AST_ADD_MATCHES_SUM: assert ({1'b0, f} == wide_sum) // R3
        else $error("add result differs from arithmetic sum");
    end
    if (!arith_mode) begin
      AST_IDLE_LOOKAHEAD: assert (g_n && p_n) // R10
        else $error("lookahead outputs active outside arithmetic");
    end
  end

endmodule

// File: tb/alu4_slice_tb.sv
module alu4_slice_tb;

  localparam int W = 4;

  typedef struct {
    logic [3:0] exp_f;
    logic       exp_g_n;
    logic       exp_p_n;
    logic       chk_gp;
    string      tag_f;
    string      tag_gp;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] a = '0, b = '0;
  logic [2:0] sel = '0;
  logic       cin = 1'b0;
  logic [3:0] f;
  logic       g_n, p_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;
  item_t sb[$];

  always #2.5 clk = ~clk;

  alu4_slice #(.WIDTH(W)) u_dut (
    .a(a), .b(b), .sel(sel), .cin(cin), .f(f), .g_n(g_n), .p_n(p_n)
  );

  function automatic void model(input int ai, input int bi, input int s, input int c,
                                output logic [3:0] rf, output logic rg_n, output logic rp_n);
    int x, y;
    bit ar;
    x = ai; y = bi; ar = 1'b1;
    rf = '0;
    case (s)
      1: x = 15 - ai;
      2: y = 15 - bi;
      3: ;
      default: ar = 1'b0;
    endcase
    if (ar) begin
      rf   = 4'((x + y + c) % 16);
      rg_n = !((x + y) > 15);
      rp_n = !((x | y) == 15);
    end else begin
      rg_n = 1'b1;
      rp_n = 1'b1;
      case (s)
        0: rf = 4'd0;
        4: rf = 4'(ai ^ bi);
        5: rf = 4'(ai | bi);
        6: rf = 4'(ai & bi);
        default: rf = 4'hF;
      endcase
    end
  endfunction

  function automatic string tag_for(input int s, input int c);
    case (s)
      0: return (c != 0) ? "R7" : "R1";
      7: return (c != 0) ? "R7" : "R2";
      3: return "R3";
      2: return "R4";
      1: return "R5";
      default: return (c != 0) ? "R7" : "R6";
    endcase
  endfunction

  task automatic drive(input int ai, input int bi, input int s, input int c,
                       input item_t it);
    @(posedge clk);
    a   <= 4'(ai);
    b   <= 4'(bi);
    sel <= 3'(s);
    cin <= 1'(c);
    sb.push_back(it);
  endtask

  // Monitor: outputs are sampled half a period after the driving edge.
  always @(negedge clk) begin
    if (!rst && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (f !== it.exp_f) begin
        errors++;
        $display("FAIL %s f actual %h expected %h (a=%h b=%h sel=%0d cin=%b)",
                 it.tag_f, f, it.exp_f, a, b, sel, cin);
      end
      if (it.chk_gp) begin
        checks++;
        if (g_n !== it.exp_g_n) begin
          errors++;
          $display("FAIL %s g_n actual %b expected %b (a=%h b=%h sel=%0d)",
                   it.tag_gp == "R10" ? "R10" : "R8", g_n, it.exp_g_n, a, b, sel);
        end
        checks++;
        if (p_n !== it.exp_p_n) begin
          errors++;
          $display("FAIL %s p_n actual %b expected %b (a=%h b=%h sel=%0d)",
                   it.tag_gp == "R10" ? "R10" : "R9", p_n, it.exp_p_n, a, b, sel);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual %0d cycles expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    item_t it;
    repeat (3) @(posedge clk);
    rst <= 1'b0;
    // Idle state after reset: clear code with zero inputs (R1, R10).
    it = '{exp_f: 4'h0, exp_g_n: 1'b1, exp_p_n: 1'b1, chk_gp: 1'b1, tag_f: "R1", tag_gp: "R10"};
    drive(0, 0, 0, 0, it);
    // Exhaustive sweep of every code, operand pair and carry (R1-R10 tags in model).
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 2; c++) begin
        for (int ai = 0; ai < 16; ai++) begin
          for (int bi = 0; bi < 16; bi++) begin
            logic [3:0] rf;
            logic rg, rp;
            model(ai, bi, s, c, rf, rg, rp);
            it.exp_f   = rf;
            it.exp_g_n = rg;
            it.exp_p_n = rp;
            it.chk_gp  = 1'b1;
            it.tag_f   = tag_for(s, c);
            it.tag_gp  = (s >= 1 && s <= 3) ? "R8" : "R10";
            drive(ai, bi, s, c, it);
          end
        end
      end
    end
    // R11: inverted operands and carry give the inverted arithmetic result.
    for (int s = 1; s < 4; s++) begin
      for (int c = 0; c < 2; c++) begin
        for (int ai = 0; ai < 16; ai++) begin
          for (int bi = 0; bi < 16; bi++) begin
            logic [3:0] rf;
            logic rg, rp;
            model(ai, bi, s, c, rf, rg, rp);
            it.exp_f  = ~rf;
            it.chk_gp = 1'b0;
            it.tag_f  = "R11";
            it.tag_gp = "";
            drive(15 - ai, 15 - bi, s, 1 - c, it);
          end
        end
      end
    end
    @(posedge clk);
    wait (sb.size() == 0);
    @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule